// File: doc/BRIEF.md
# Quasi-Bidirectional Port Register with Memory-Interface Override

This block is one 8-bit parallel I/O port of a microcontroller-style core, placed on the special-function-register bus. It holds an output latch and drives each pin open-drain: a pin is pulled low when the value it should carry is 0, and is otherwise released to a weak pull-up. Software reads back either the synchronized pin levels or the latch, and the choice depends on the kind of read.

The lower pins can be taken over by an external memory interface. They then carry upper address lines or chip enables. A pin takes this role only when its control bit (`mem_sel`) is set and its latch bit holds 1. While it is held this way, bus writes cannot change its latch bit and a normal read returns 1 for it. The two upper pins carry serial-port alternates, a transmit/shift-clock output and a receive/bidirectional-data line. These are applied as override inputs that are ANDed with the latch bit, so the latch must hold 1 for the alternate signal to reach the pin.

Bus accesses are strobe-based. A single-cycle write strobe loads the latch. A read strobe, which may be qualified as part of a read-modify-write cycle, captures read data into a register that is visible one clock later.

Top module: `qbp_port`

## Requirements
- R1: After reset all latch bits are 1, every `pin_drv_low` bit is 0 and `rd_data` is 0x00.
- R2: A write (`wr_en`=1) loads `wr_data` into every latch bit whose pin is not held by the memory interface. Held bits keep their value. Without a write the latch does not change.
- R3: A normal read (`rd_en`=1, `rd_rmw`=0) returns 1 in every bit position held by the memory interface, whatever the pin level.
- R4: A normal read returns the pin level for each bit in general-purpose mode. The level is taken after a two-flop synchronizer, so a pin change is visible to a read strobe issued two or more clocks later.
- R5: A read with `rd_rmw`=1 returns the latch contents, not the pin levels.
- R6: `rd_data` updates at the clock edge that samples `rd_en`=1. It keeps its value in every cycle without a read strobe.
- R7: A pin whose latch bit is 0 is always driven low (`pin_drv_low`=1).
- R8: A pin held by the memory interface is driven low exactly when its `mem_out` bit is 0. It is released when that bit is 1.
- R9: With `ser_en`=1, bit 7 is driven low unless both latch bit 7 and `ser_tx` are 1, and bit 6 is driven low unless both latch bit 6 and `ser_rx_drv` are 1. With `ser_en`=0, those pins follow their latch bits only.
- R10: Only bits 0 to 5 can be taken by the memory interface. A set `mem_sel` bit 6 or 7 has no effect on writes, reads or drive.
- R11: A pin whose `mem_sel` bit is set but whose latch bit is 0 stays in general-purpose mode. A write can then load it, and loading a 1 hands the pin over to the memory interface.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_rmw | input | 1 | Read is part of a read-modify-write cycle (returns latch) |
| rd_data | output | 8 | Registered read data |
| mem_sel | input | 8 | Per-bit memory-interface select from the port control register |
| mem_out | input | 8 | Signal levels the memory interface wants on held pins |
| ser_en | input | 1 | Serial alternate functions active on bits 7 and 6 |
| ser_tx | input | 1 | Serial transmit data or shift clock for bit 7 |
| ser_rx_drv | input | 1 | Serial synchronous-mode data drive for bit 6 (1 releases) |
| pin_in | input | 8 | Pin levels as seen at the pads |
| pin_drv_low | output | 8 | 1 pulls the pin low; 0 releases it to the weak pull-up |

## Verification
Every write value from 0x00 to 0xFF is applied under several memory-select patterns: none, all six eligible bits, all eight bits, and two alternating masks. Each write is followed by a read-modify-write read, a normal read against a changing external pin pattern, and a check of the drive outputs. Comparing the latch read with the pin read tells masked-write errors apart from read-path forcing errors. The all-eight pattern shows whether the upper bits are wrongly treated as eligible. A full sweep of `mem_out` checks the drive of held pins. All four serial override combinations are tried against each latch state of the upper bits. A sequence with the select set while the latch holds 0 covers the handover rule.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_PIN   = 2'd1,
    RD_LATCH = 2'd2
  } rd_kind_e;

  function automatic rd_kind_e rd_kind(input logic rd_en, input logic rmw);
    if (!rd_en)   return RD_NONE;
    else if (rmw) return RD_LATCH;
    else          return RD_PIN;
  endfunction
endpackage

// File: rtl/qbp_sync.sv
module qbp_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int k = 1; k < STAGES; k++) stg_d[k] = stg_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '1;
    end else begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= stg_d[k];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/qbp_latch.sv
module qbp_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] keep,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (wr_en) q_nxt = (q_r & keep) | (wr_data & ~keep);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '1;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  assert_keep_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q_r & $past(keep)) == $past(keep)));
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q_r));
endmodule

// File: rtl/qbp_pin_drv.sv
module qbp_pin_drv #(
  parameter int W = 8
) (
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] mem_act,
  input  logic [W-1:0] mem_out,
  input  logic         ser_en,
  input  logic         ser_tx,
  input  logic         ser_rx_drv,
  output logic [W-1:0] drv_low
);
  localparam int TX_BIT = W - 1;
  localparam int RX_BIT = W - 2;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic alt_v;
    if (i == TX_BIT) begin : g_tx
      assign alt_v = ser_en ? ser_tx : 1'b1;
    end else if (i == RX_BIT) begin : g_rx
      assign alt_v = ser_en ? ser_rx_drv : 1'b1;
    end else begin : g_mem
      assign alt_v = mem_act[i] ? mem_out[i] : 1'b1;
    end
    assign drv_low[i] = ~(latch_q[i] & alt_v);
  end
endmodule

// File: rtl/qbp_port.sv
module qbp_port #(
  parameter int           W           = 8,
  parameter logic [W-1:0] MEM_MASK    = 8'h3F,
  parameter int           SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic         rd_rmw,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] mem_sel,
  input  logic [W-1:0] mem_out,
  input  logic         ser_en,
  input  logic         ser_tx,
  input  logic         ser_rx_drv,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_drv_low
);
  import qbp_pkg::*;

  logic [W-1:0] latch_q, pin_s, mem_act, rd_q, rd_nxt;
  rd_kind_e     kind;

  assign mem_act = mem_sel & MEM_MASK & latch_q;

  qbp_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s));

  qbp_latch #(.W(W)) latch_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .keep(mem_act), .q(latch_q));

  qbp_pin_drv #(.W(W)) drv_i (
    .latch_q(latch_q), .mem_act(mem_act), .mem_out(mem_out),
    .ser_en(ser_en), .ser_tx(ser_tx), .ser_rx_drv(ser_rx_drv),
    .drv_low(pin_drv_low));

  assign kind = rd_kind(rd_en, rd_rmw);

  always_comb begin
    rd_nxt = rd_q;
    case (kind)
      RD_PIN:   rd_nxt = pin_s | mem_act;
      RD_LATCH: rd_nxt = latch_q;
      default:  rd_nxt = rd_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_nxt;
  end

  assign rd_data = rd_q;

  assert_forced_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_rmw) |=> ((rd_data & $past(mem_act)) == $past(mem_act)));
  assert_rmw_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_rmw) |=> (rd_data == $past(latch_q)));
  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  assert_latch_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~latch_q & ~pin_drv_low) == '0));
  assert_upper_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_act & ~MEM_MASK) == '0));
endmodule

// File: tb/qbp_port_tb_top.sv
module qbp_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, rd_rmw = 1'b0;
  logic [7:0] wr_data = '0, mem_sel = '0, mem_out = '1, ext = '1;
  logic       ser_en = 1'b0, ser_tx = 1'b1, ser_rx_drv = 1'b1;
  logic [7:0] rd_data, pin_drv_low, pin_in;
  logic [7:0] lm;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign pin_in = ext & ~pin_drv_low;

  qbp_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_rmw(rd_rmw), .rd_data(rd_data),
    .mem_sel(mem_sel), .mem_out(mem_out), .ser_en(ser_en),
    .ser_tx(ser_tx), .ser_rx_drv(ser_rx_drv), .pin_in(pin_in),
    .pin_drv_low(pin_drv_low));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] act_m();
    return mem_sel & 8'h3F & lm;
  endfunction

  function automatic logic [7:0] drv_m();
    logic [7:0] a, v;
    a = act_m();
    v = lm & ((a & mem_out) | ~a);
    if (ser_en) v[7] = v[7] & ser_tx;
    if (ser_en) v[6] = v[6] & ser_rx_drv;
    return ~v;
  endfunction

  task automatic wr(input logic [7:0] d);
    logic [7:0] a;
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    a = act_m();
    @(negedge clk); wr_en = 1'b0;
    lm = (lm & a) | (d & ~a);
  endtask

  task automatic rd(input logic rmw, output logic [7:0] q);
    @(negedge clk); rd_en = 1'b1; rd_rmw = rmw;
    @(negedge clk); rd_en = 1'b0; rd_rmw = 1'b0;
    q = rd_data;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] q, prev;
    logic [7:0] sels [5];
    sels[0] = 8'h00; sels[1] = 8'h3F; sels[2] = 8'hFF; sels[3] = 8'h55; sels[4] = 8'hA5;
    lm = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 rd_data reset", rd_data, 8'h00);
    chk("R1 drive reset", pin_drv_low, 8'h00);
    rst_n = 1'b1;
    rd(1'b1, q); chk("R1 latch reset", q, 8'hFF);

    // R2 R3 R4 R5 R10: sweep writes under select patterns
    for (int s = 0; s < 5; s++) begin
      for (int d = 0; d < 256; d++) begin
        mem_sel = 8'h00; wr(8'hFF);
        mem_sel = sels[s]; wr(d[7:0]);
        ext = d[7:0] ^ 8'hC3 ^ 8'(s * 37);
        rd(1'b1, q); chk("R2/R5 rmw latch", q, lm);
        chk("R7/R10 drive", pin_drv_low, drv_m());
        repeat (2) @(negedge clk);
        rd(1'b0, q); chk("R3/R4/R10 pin read", q, act_m() | (ext & ~drv_m()));
      end
    end

    // R4: sync latency, change visible to a strobe two clocks later
    mem_sel = 8'h00; wr(8'hFF); ext = 8'hFF; repeat (3) @(negedge clk);
    ext = 8'h0F; @(negedge clk); @(negedge clk);
    rd(1'b0, q); chk("R4 sync latency", q, 8'h0F);

    // R6: update timing and hold
    ext = 8'hF0; repeat (3) @(negedge clk);
    prev = rd_data;
    @(negedge clk); rd_en = 1'b1; #1;
    chk("R6 not before edge", rd_data, prev);
    @(negedge clk); rd_en = 1'b0;
    chk("R6 after edge", rd_data, 8'hF0);
    ext = 8'h33; repeat (4) @(negedge clk);
    chk("R6 hold", rd_data, 8'hF0);

    // R8: memory drive sweep
    mem_sel = 8'h00; wr(8'hFF); mem_sel = 8'h3F;
    for (int m = 0; m < 256; m++) begin
      mem_out = m[7:0]; #1;
      chk("R8 mem drive", pin_drv_low, ~m[7:0] & 8'h3F);
    end
    mem_out = 8'hFF;

    // R9: serial overrides
    mem_sel = 8'h00;
    for (int u = 0; u < 4; u++) begin
      wr({u[1:0], 6'h3F});
      for (int e = 0; e < 2; e++)
        for (int c = 0; c < 4; c++) begin
          ser_en = e[0]; ser_tx = c[1]; ser_rx_drv = c[0]; #1;
          chk("R9 serial drive", pin_drv_low, drv_m());
        end
    end
    ser_en = 1'b0; ser_tx = 1'b1; ser_rx_drv = 1'b1;

    // R11: select with latch 0 stays GPIO until a 1 is written
    mem_sel = 8'h00; wr(8'h00); mem_sel = 8'h3F; #1;
    chk("R11 low while sel", pin_drv_low, 8'hFF);
    wr(8'h0A); rd(1'b1, q); chk("R11 writable", q, 8'h0A);
    wr(8'h00); rd(1'b1, q); chk("R11 handover keeps", q, 8'h0A);
    ext = 8'h00; repeat (3) @(negedge clk);
    rd(1'b0, q); chk("R11 held reads one", q, 8'h0A);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule